// File: doc/BRIEF.md
# Serial-In Shift Register with Strobed Holding Latch

The block turns a serial bit stream into a parallel word. A chain of stages advances one place on every rising edge of the shift clock, taking the serial input into the stage nearest the input. A holding stage sits behind the chain. While the strobe is high it is transparent and follows the chain. While the strobe is low it keeps the last word, so the parallel bus stays steady during a new shift sequence.

The parallel bus is driven only while output enable is high; otherwise every bit floats. A per-bit drive-enable vector reports the bus state without relying on resolved high-impedance values. Two serial cascade outputs let several blocks form one longer register. The rising-edge output carries the last stage as soon as it changes. The falling-edge output repeats it half a clock later, which gives a downstream block a full half period of hold margin when clock edges are slow. An active-low asynchronous reset clears everything.

The block has no state machine. It has two modes, each set by one input: the holding stage is in FOLLOW while the strobe is high and in HOLD while it is low, and the bus is DRV_ON while output enable is high and DRV_HIZ while it is low.

Top module: `shift_store_reg`

## Requirements
- R1: On every rising shift-clock edge, stage 0 loads the serial input and each stage k>0 loads the old value of stage k-1.
- R2: The rising-edge cascade output changes only on a rising edge, where it takes the value stage STAGES-2 held before that edge. This equals the new content of the last stage.
- R3: The falling-edge cascade output loads the last stage on each falling shift-clock edge and keeps its value between falling edges.
- R4: While the strobe is high, the holding stage follows the shift chain, including changes from shifts made while the strobe stays high.
- R5: While the strobe is low, the holding stage keeps its value through any number of shifts.
- R6: With output enable low, all drive-enable bits are 0 and the parallel bus is high-impedance. With it high, all drive-enable bits are 1 and the bus shows the holding stage.
- R7: Output enable changes neither the shift chain nor the holding stage, and it does not gate either cascade output.
- R8: Parallel bit n shows holding stage n, with stage 0 nearest the serial input. A byte shifted most significant bit first therefore appears on the bus unchanged.
- R9: Reset low clears the shift chain, the holding stage and both cascade outputs to 0 at once, without a clock.
- R10: When a second block takes its serial input from the falling-edge cascade output of a first block, and both share one clock, the two act as one chain of 2*STAGES stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdat_i | input | 1 | Serial data input |
| strobe_i | input | 1 | Holding stage transparent when high |
| oe_i | input | 1 | Parallel bus drive enable |
| par_q_o | output | STAGES | Tri-state parallel bus |
| par_drv_o | output | STAGES | Per-bit drive enable of the bus |
| casc_rise_o | output | 1 | Cascade output updated on rising edges |
| casc_fall_o | output | 1 | Cascade output updated on falling edges |

## Verification
The hardest state to reach is the half period between a rising and the next falling shift-clock edge, where the two cascade outputs disagree. The bench drives the shift clock as a gated copy of its own clock. This lets it stop after a rising edge, check that the falling-edge output still holds the old last stage, and then release the falling edge. A chain is preloaded so that the last two stages differ, which makes the disagreement visible. Strobe pulses are placed while the shift clock is stopped, so hold and follow behaviour are checked separately from shifting.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    parameter int unsigned SSR_STAGES = 8;

    typedef enum logic {
        DRV_HIZ = 1'b0,
        DRV_ON  = 1'b1
    } drive_mode_e;
endpackage

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
    input  logic              sclk_i,
    input  logic              rst_ni,
    input  logic              sdat_i,
    output logic [STAGES-1:0] chain_o,
    output logic              casc_rise_o,
    output logic              casc_fall_o
);
    localparam int unsigned LAST = STAGES - 1;
    localparam int unsigned PREV = STAGES - 2;

    logic armed_q;

    // stage 0 takes the serial bit, the rest move one place up
    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) chain_o <= '0;
        else         chain_o <= {chain_o[PREV:0], sdat_i};
    end

    // separate flop fed from the stage below the last one
    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) casc_rise_o <= 1'b0;
        else         casc_rise_o <= chain_o[PREV];
    end

    // half-period delayed copy of the last stage
    always_ff @(negedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) casc_fall_o <= 1'b0;
        else         casc_fall_o <= chain_o[LAST];
    end

    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    // R2
    casc_rise_match_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        armed_q |-> (casc_rise_o == chain_o[LAST]));

    // R3
    casc_fall_trail_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        armed_q |-> (casc_fall_o == chain_o[LAST]));
endmodule

// File: rtl/ssr_store_latch.sv
module ssr_store_latch #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
    input  logic              rst_ni,
    input  logic              strobe_i,
    input  logic [STAGES-1:0] chain_i,
    output logic [STAGES-1:0] store_o
);
    // FOLLOW while strobe is high, HOLD while it is low
    always_latch begin
        if (!rst_ni)       store_o <= '0;
        else if (strobe_i) store_o <= chain_i;
    end
endmodule

// File: rtl/ssr_out_gate.sv
module ssr_out_gate #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
    input  logic              oe_i,
    input  logic [STAGES-1:0] store_i,
    output wire  [STAGES-1:0] par_q_o,
    output logic [STAGES-1:0] par_drv_o
);
    import ssr_pkg::*;

    drive_mode_e mode;
    assign mode = oe_i ? DRV_ON : DRV_HIZ;

    for (genvar i = 0; i < STAGES; i++) begin : g_bit
        assign par_drv_o[i] = (mode == DRV_ON);
        assign par_q_o[i]   = par_drv_o[i] ? store_i[i] : 1'bz;
    end
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
    input  logic              sclk_i,
    input  logic              rst_ni,
    input  logic              sdat_i,
    input  logic              strobe_i,
    input  logic              oe_i,
    output wire  [STAGES-1:0] par_q_o,
    output logic [STAGES-1:0] par_drv_o,
    output logic              casc_rise_o,
    output logic              casc_fall_o
);
    logic [STAGES-1:0] chain;
    logic [STAGES-1:0] store;

    ssr_shift_chain #(.STAGES(STAGES)) u_chain (
        .sclk_i     (sclk_i),
        .rst_ni     (rst_ni),
        .sdat_i     (sdat_i),
        .chain_o    (chain),
        .casc_rise_o(casc_rise_o),
        .casc_fall_o(casc_fall_o)
    );

    ssr_store_latch #(.STAGES(STAGES)) u_store (
        .rst_ni  (rst_ni),
        .strobe_i(strobe_i),
        .chain_i (chain),
        .store_o (store)
    );

    // R4
    store_follow_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        strobe_i |-> (store == chain));

    ssr_out_gate #(.STAGES(STAGES)) u_gate (
        .oe_i     (oe_i),
        .store_i  (store),
        .par_q_o  (par_q_o),
        .par_drv_o(par_drv_o)
    );

    // R6
    drive_on_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        oe_i |-> (par_drv_o == {STAGES{1'b1}}));

    // R6
    drive_off_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        !oe_i |-> (par_drv_o == '0));
endmodule

// File: tb/sim_shift_store_reg.sv
module sim_shift_store_reg;
    localparam int W = 8;
    localparam logic [W-1:0] PAT [0:5] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h5A};

    logic clk = 1'b0;
    logic run = 1'b0;
    logic sclk;
    logic rst_n = 1'b0;
    logic sdat = 1'b0;
    logic strobe = 1'b0;
    logic oe = 1'b1;
    wire  [W-1:0] q0, q1;
    logic [W-1:0] drv0, drv1;
    logic rise0, fall0, rise1, fall1;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    assign sclk = clk & run;
    always #4 clk = ~clk;

    shift_store_reg #(.STAGES(W)) u0 (
        .sclk_i(sclk), .rst_ni(rst_n), .sdat_i(sdat), .strobe_i(strobe), .oe_i(oe),
        .par_q_o(q0), .par_drv_o(drv0), .casc_rise_o(rise0), .casc_fall_o(fall0));

    shift_store_reg #(.STAGES(W)) u1 (
        .sclk_i(sclk), .rst_ni(rst_n), .sdat_i(fall0), .strobe_i(strobe), .oe_i(oe),
        .par_q_o(q1), .par_drv_o(drv1), .casc_rise_o(rise1), .casc_fall_o(fall1));

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one full shift clock pulse, ends after the falling edge
    task automatic shift_bit(input logic b);
        @(negedge clk); sdat = b; run = 1'b1;
        @(negedge clk); run = 1'b0;
        #1;
    endtask

    task automatic shift_byte(input logic [W-1:0] v);
        for (int i = W - 1; i >= 0; i--) shift_bit(v[i]);
    endtask

    task automatic pulse_strobe;
        @(negedge clk); strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
        #1;
    endtask

    initial begin
        logic [W-1:0] prev;
        logic [W-1:0] run_exp;
        logic [15:0]  word;
        #5;
        // R9 reset state
        check(q0 == '0, "R9 bus after reset", 16'(q0), 0);
        check({rise0, fall0} == 2'b00, "R9 cascade after reset", 16'({rise0, fall0}), 0);
        @(negedge clk); rst_n = 1'b1;

        prev = '0;
        for (int k = 0; k < 6; k++) begin
            shift_byte(PAT[k]);
            check(q0 == prev, "R5 hold during shifting", 16'(q0), 16'(prev));
            check(rise0 == PAT[k][W-1], "R2 rise output", 16'(rise0), 16'(PAT[k][W-1]));
            check(fall0 == PAT[k][W-1], "R3 fall output", 16'(fall0), 16'(PAT[k][W-1]));
            pulse_strobe();
            check(q0 == PAT[k], "R1 R8 word on bus", 16'(q0), 16'(PAT[k]));
            check(drv0 == '1, "R6 drive on", 16'(drv0), 16'hFF);
            prev = PAT[k];
        end

        // R4 transparency while shifting with strobe high
        @(negedge clk); strobe = 1'b1;
        run_exp = prev;
        for (int i = 0; i < 3; i++) begin
            shift_bit(i[0] ? 1'b0 : 1'b1);
            run_exp = {run_exp[W-2:0], (i[0] ? 1'b0 : 1'b1)};
            check(q0 == run_exp, "R4 follow chain", 16'(q0), 16'(run_exp));
        end
        @(negedge clk); strobe = 1'b0;

        // R2/R3 between the rising and falling edge
        shift_byte(8'h40);
        @(negedge clk); sdat = 1'b0; run = 1'b1;
        @(posedge clk); #1;
        check(rise0 == 1'b1, "R2 rise takes old stage 6", 16'(rise0), 1);
        check(fall0 == 1'b0, "R3 fall holds until falling edge", 16'(fall0), 0);
        @(negedge clk); run = 1'b0; #1;
        check(fall0 == 1'b1, "R3 fall after falling edge", 16'(fall0), 1);

        // R6/R7 output enable
        @(negedge clk); oe = 1'b0; #1;
        check(drv0 == '0, "R6 drive off", 16'(drv0), 0);
        shift_byte(8'h96);
        pulse_strobe();
        check(rise0 == 1'b1, "R7 rise not gated", 16'(rise0), 1);
        check(fall0 == 1'b1, "R7 fall not gated", 16'(fall0), 1);
        check(drv0 == '0, "R6 still off", 16'(drv0), 0);
        @(negedge clk); oe = 1'b1; #1;
        check(drv0 == '1, "R6 drive back on", 16'(drv0), 16'hFF);
        check(q0 == 8'h96, "R7 state kept while disabled", 16'(q0), 16'h96);

        // R10 two blocks as one 16-stage chain
        word = 16'hC3A1;
        for (int i = 15; i >= 0; i--) shift_bit(word[i]);
        pulse_strobe();
        check(q0 == word[7:0], "R10 low byte in first block", 16'(q0), 16'(word[7:0]));
        check(q1 == word[15:8], "R10 high byte in second block", 16'(q1), 16'(word[15:8]));

        // R9 asynchronous reset mid-run
        @(negedge clk); #1; rst_n = 1'b0; #1;
        check(q0 == '0, "R9 bus cleared", 16'(q0), 0);
        check(q1 == '0, "R9 second bus cleared", 16'(q1), 0);
        check({rise0, fall0} == 2'b00, "R9 cascade cleared", 16'({rise0, fall0}), 0);
        @(negedge clk); rst_n = 1'b1;
        pulse_strobe();
        check(q0 == '0, "R9 chain cleared", 16'(q0), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule